// File: doc/BRIEF.md
# Register-Access SPI Transaction Master

This block carries out one complete register access to an SPI peripheral that frames each access with a four-byte command header and can hold the master off with wait states. The requester supplies a direction, a length and a 24-bit register address. The master lowers chip select and shifts out the header. It then reads the peripheral's ready flag from the final header bit. If the peripheral is stalling, the master clocks in single bytes until one ends with a set bit. Only then does it move the data bytes: write bytes are pulled from a byte-wide ready/valid input and read bytes are pushed out as one-cycle strobes.

The serial port runs in mode 0 (clock idle low, data launched on the falling edge, sampled on the rising edge, most significant bit first). Each half period of the serial clock lasts `sclk_div + 1` system clocks. A stall that outlasts `TIMEOUT_CYCLES` system clocks ends the access: chip select is released and the access finishes with an error. For a read, a block of zero bytes is delivered in place of the data.

Top module: `spi_txn_master`

## Requirements
- R1: The first header byte carries 1 in bit 7 for a read and 0 for a write, always 1 in bit 6, and the byte count minus one (`req_len_m1`) in bits 5:0.
- R2: Header bytes two, three and four carry `req_addr[23:16]`, `req_addr[15:8]` and `req_addr[7:0]` in that order.
- R3: A successful access moves exactly `req_len_m1 + 1` data bytes (1 to 64), so it produces exactly 8 × (4 + poll bytes + data bytes) rising serial-clock edges.
- R4: Chip select goes low before the first serial-clock edge and rises exactly once per access: after the last data bit, or when the stall timeout fires. No serial-clock pulse occurs while chip select is high, and chip select is already high when `done` is raised.
- R5: If the bit sampled on the 32nd header clock is 1, the first data byte follows the header with no poll byte.
- R6: If that bit is 0, the master clocks in whole poll bytes with MOSI low until a byte whose last-received bit is 1 arrives, and the data phase starts right after it.
- R7: After `TIMEOUT_CYCLES` system clocks spent polling, the master releases chip select and finishes with `error` high. A poll byte that completes in that same cycle and shows ready takes priority, and the access then succeeds.
- R8: When a read fails, the read stream delivers `req_len_m1 + 1` bytes of value 0x00, and all of them arrive after chip select has risen.
- R9: MOSI never changes on a rising serial-clock edge. Each serial-clock high phase lasts `sclk_div + 1` system clocks.
- R10: A request is taken only while `busy` is low. A `req_valid` pulse during an access does not change that access and does not start a second one.
- R11: `done` is high for exactly one cycle per access, and `error` is high only together with `done`.
- R12: For a write, each data byte is taken through a `wr_valid`/`wr_ready` handshake. The bytes are sent in the order they were taken, and the serial clock holds low while the master waits for a byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_div | input | DIV_W | Serial half period in system clocks, minus one |
| req_valid | input | 1 | Start an access (taken while idle) |
| req_read | input | 1 | 1 = read, 0 = write |
| req_len_m1 | input | 6 | Data byte count minus one |
| req_addr | input | 24 | Register address |
| busy | output | 1 | Access in progress |
| wr_data | input | 8 | Write byte |
| wr_valid | input | 1 | Write byte available |
| wr_ready | output | 1 | Master waiting for a write byte |
| rd_data | output | 8 | Read byte |
| rd_valid | output | 1 | One-cycle strobe for `rd_data` |
| done | output | 1 | Access finished (one cycle) |
| error | output | 1 | Access ended by stall timeout (with `done`) |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The stall timeout and the completion of a poll byte that shows ready can land on the same system clock. Poll bytes start on a fixed clock-divider phase, so the bench builds this case directly: with a half period of two clocks and a 96-cycle timeout, the third poll byte ends on the expiry cycle. When that byte signals ready, the access must succeed with the full data and no error. When it does not, the access must fail, release chip select and deliver zeros. The random accesses mix dividers and stall lengths. Each one is judged by a bench predictor that fails an access only when the total poll time strictly exceeds the timeout.

// File: rtl/spi_txn_master.sv
module spi_txn_master #(
  parameter int DIV_W          = 8,
  parameter int TIMEOUT_CYCLES = 10_000_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] sclk_div,
  input  logic             req_valid,
  input  logic             req_read,
  input  logic [5:0]       req_len_m1,
  input  logic [23:0]      req_addr,
  output logic             busy,
  input  logic [7:0]       wr_data,
  input  logic             wr_valid,
  output logic             wr_ready,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  output logic             done,
  output logic             error,
  output logic             sclk,
  output logic             cs_n,
  output logic             mosi,
  input  logic             miso
);
  localparam int TMO_W = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(TIMEOUT_CYCLES - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_HDR, S_POLL, S_WLOAD, S_DATA, S_ZFILL, S_FIN
  } state_t;

  state_t           state;
  logic             is_read, fail_q;
  logic [5:0]       len_q, cnt_q;
  logic [23:0]      addr_q;
  logic [1:0]       hdr_idx;
  logic [2:0]       bit_cnt;
  logic [7:0]       tx_sh, rx_sh;
  logic [DIV_W-1:0] div_cnt;
  logic [TMO_W-1:0] tmo_cnt;
  logic             sclk_q, cs_q, rdv_q, done_q, err_q;
  logic [7:0]       rdd_q;

  logic shifting, tick, rise, fall, byte_end, tmo_hit;
  logic [7:0] next_addr_byte;

  assign shifting = (state == S_HDR) || (state == S_POLL) || (state == S_DATA);
  assign tick     = shifting && (div_cnt == sclk_div);
  assign rise     = tick && !sclk_q;
  assign fall     = tick && sclk_q;
  assign byte_end = fall && (bit_cnt == 3'd7);
  assign tmo_hit  = (state == S_POLL) && (tmo_cnt == TMO_LAST);

  assign next_addr_byte = (hdr_idx == 2'd0) ? addr_q[23:16] :
                          (hdr_idx == 2'd1) ? addr_q[15:8]  : addr_q[7:0];

  assign busy     = (state != S_IDLE);
  assign wr_ready = (state == S_WLOAD);
  assign rd_data  = rdd_q;
  assign rd_valid = rdv_q;
  assign done     = done_q;
  assign error    = err_q;
  assign sclk     = sclk_q;
  assign cs_n     = cs_q;
  assign mosi     = tx_sh[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      is_read <= 1'b0;
      fail_q  <= 1'b0;
      len_q   <= '0;
      cnt_q   <= '0;
      addr_q  <= '0;
      hdr_idx <= '0;
      bit_cnt <= '0;
      tx_sh   <= '0;
      rx_sh   <= '0;
      div_cnt <= '0;
      tmo_cnt <= '0;
      sclk_q  <= 1'b0;
      cs_q    <= 1'b1;
      rdv_q   <= 1'b0;
      rdd_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      rdv_q  <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;

      if (!shifting || tick) div_cnt <= '0;
      else                   div_cnt <= div_cnt + 1'b1;

      if (rise) begin
        sclk_q <= 1'b1;
        rx_sh  <= {rx_sh[6:0], miso};
      end
      if (fall) begin
        sclk_q  <= 1'b0;
        bit_cnt <= bit_cnt + 1'b1;
        tx_sh   <= {tx_sh[6:0], 1'b0};
      end

      case (state)
        S_IDLE: begin
          if (req_valid) begin
            is_read <= req_read;
            len_q   <= req_len_m1;
            addr_q  <= req_addr;
            fail_q  <= 1'b0;
            hdr_idx <= '0;
            bit_cnt <= '0;
            sclk_q  <= 1'b0;
            cs_q    <= 1'b0;
            tx_sh   <= {req_read, 1'b1, req_len_m1};
            state   <= S_HDR;
          end
        end
        S_HDR: begin
          if (byte_end) begin
            if (hdr_idx != 2'd3) begin
              hdr_idx <= hdr_idx + 1'b1;
              tx_sh   <= next_addr_byte;
            end else if (rx_sh[0]) begin
              cnt_q <= '0;
              tx_sh <= '0;
              state <= is_read ? S_DATA : S_WLOAD;
            end else begin
              tx_sh   <= '0;
              tmo_cnt <= '0;
              state   <= S_POLL;
            end
          end
        end
        S_POLL: begin
          tmo_cnt <= tmo_cnt + 1'b1;
          if (byte_end && rx_sh[0]) begin
            cnt_q <= '0;
            tx_sh <= '0;
            state <= is_read ? S_DATA : S_WLOAD;
          end else if (tmo_hit) begin
            cs_q   <= 1'b1;
            sclk_q <= 1'b0;
            fail_q <= 1'b1;
            cnt_q  <= '0;
            state  <= is_read ? S_ZFILL : S_FIN;
          end
        end
        S_WLOAD: begin
          if (wr_valid) begin
            tx_sh <= wr_data;
            state <= S_DATA;
          end
        end
        S_DATA: begin
          if (byte_end) begin
            if (is_read) begin
              rdv_q <= 1'b1;
              rdd_q <= rx_sh;
            end
            if (cnt_q == len_q) begin
              state <= S_FIN;
            end else begin
              cnt_q <= cnt_q + 1'b1;
              tx_sh <= '0;
              if (!is_read) state <= S_WLOAD;
            end
          end
        end
        S_ZFILL: begin
          rdv_q <= 1'b1;
          rdd_q <= 8'h00;
          if (cnt_q == len_q) state <= S_FIN;
          else                cnt_q <= cnt_q + 1'b1;
        end
        S_FIN: begin
          cs_q   <= 1'b1;
          done_q <= 1'b1;
          err_q  <= fail_q;
          state  <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_txn_master_chk.sv
module spi_txn_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sclk,
  input logic       cs_n,
  input logic       mosi,
  input logic       busy,
  input logic       done,
  input logic       error,
  input logic       rd_valid,
  input logic [7:0] rd_data,
  input logic       wr_ready
);
  AST_SCLK_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n) sclk |-> !cs_n) else $error("sclk outside frame"); // R4
  AST_DESELECT_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n) done |-> cs_n) else $error("cs low at done"); // R4
  AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> cs_n) else $error("cs low while idle"); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done) else $error("done longer than one cycle"); // R11
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n) error |-> done) else $error("error without done"); // R11
  AST_FAIL_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (rd_valid && cs_n) |-> (rd_data == 8'h00)) else $error("nonzero fill byte"); // R8
  AST_MOSI_STABLE_RISE: assert property (@(posedge clk) disable iff (!rst_n) $rose(sclk) |-> $stable(mosi)) else $error("mosi moved on rising edge"); // R9
  AST_WR_PAUSE: assert property (@(posedge clk) disable iff (!rst_n) wr_ready |-> (!sclk && !cs_n)) else $error("clock running while waiting"); // R12
endmodule

bind spi_txn_master spi_txn_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
  .busy(busy), .done(done), .error(error), .rd_valid(rd_valid),
  .rd_data(rd_data), .wr_ready(wr_ready)
);

// File: tb/tb_spi_txn_master.sv
module tb_spi_txn_master;
  localparam int TMO = 96;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  sclk_div = 8'd0;
  logic        req_valid = 1'b0;
  logic        req_read = 1'b0;
  logic [5:0]  req_len_m1 = 6'd0;
  logic [23:0] req_addr = 24'd0;
  logic        busy;
  logic [7:0]  wr_data = 8'd0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [7:0]  rd_data;
  logic        rd_valid;
  logic        done, error, sclk, cs_n, mosi;
  logic        miso;

  int checks = 0;
  int errors = 0;
  bit abort = 1'b0;

  spi_txn_master #(.DIV_W(8), .TIMEOUT_CYCLES(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .sclk_div(sclk_div), .req_valid(req_valid),
    .req_read(req_read), .req_len_m1(req_len_m1), .req_addr(req_addr),
    .busy(busy), .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .rd_data(rd_data), .rd_valid(rd_valid), .done(done), .error(error),
    .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso)
  );

  always #4 clk = ~clk;

  // Peripheral model
  int          stall_n = 0;
  logic [7:0]  rdat [0:63];
  logic [7:0]  wbuf [0:63];
  logic [7:0]  cap  [0:255];
  logic [10:0] bitcnt = 11'd0;
  int          rises = 0;
  int          bad_rises = 0;

  function automatic logic [7:0] resp(input int b);
    if (b < 3)              return 8'hC0 | 8'(b);
    if (b == 3)             return (stall_n == 0) ? 8'h5B : 8'h5A;
    if (b < 4 + stall_n)    return (b == 3 + stall_n) ? 8'h3D : 8'h3C;
    if (b - 4 - stall_n < 64) return rdat[b - 4 - stall_n];
    return 8'h00;
  endfunction

  always_comb begin
    logic [7:0] rb;
    rb = resp(int'(bitcnt[10:3]));
    miso = cs_n ? 1'b0 : rb[3'd7 - bitcnt[2:0]];
  end

  always @(negedge sclk or posedge cs_n) begin
    if (cs_n) bitcnt <= 11'd0;
    else      bitcnt <= bitcnt + 11'd1;
  end

  always @(posedge sclk) begin
    rises = rises + 1;
    if (cs_n) bad_rises = bad_rises + 1;
    else cap[bitcnt[10:3]][3'd7 - bitcnt[2:0]] = mosi;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d (0x%0h), expected %0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  task automatic run_txn(input bit rd, input int len, input logic [23:0] a,
                         input int div, input int n, input bit poke);
    int r0, b0, dcnt, csr, rcnt, hi, widx, loops, post, bad;
    bit pend, errv, fail, prev_cs, busy_poke;
    logic [7:0] rbuf [0:63];
    logic [7:0] h0;
    if (abort) return;
    stall_n = n;
    for (int i = 0; i < 64; i++) begin
      rdat[i] = 8'($urandom);
      wbuf[i] = 8'($urandom);
      rbuf[i] = 8'hxx;
    end
    fail = (n > 0) && (16 * (div + 1) * n > TMO);
    r0 = rises; b0 = bad_rises;
    dcnt = 0; csr = 0; rcnt = 0; hi = 0; widx = 0; loops = 0; post = 0;
    pend = 0; errv = 0; busy_poke = 1;
    @(negedge clk);
    sclk_div = 8'(div); req_read = rd; req_len_m1 = 6'(len - 1);
    req_addr = a; req_valid = 1'b1; wr_valid = 1'b0; wr_data = wbuf[0];
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R10 busy after accept", int'(busy), 1);
    prev_cs = cs_n;
    while (post < 3) begin
      @(negedge clk);
      loops++;
      if (loops > 30000) begin
        chk(1'b0, "watchdog", loops, 30000);
        abort = 1'b1;
        break;
      end
      if (sclk) hi++;
      if (rd_valid) begin
        if (rcnt < 64) rbuf[rcnt] = rd_data;
        rcnt++;
      end
      if (done) begin dcnt++; errv = error; end
      if (cs_n && !prev_cs) csr++;
      prev_cs = cs_n;
      if (!rd) begin
        if (pend) begin
          pend = 1'b0;
          widx++;
          wr_valid = ($urandom % 4) != 0;
          wr_data = wbuf[widx < 64 ? widx : 63];
        end else if (wr_ready && wr_valid) begin
          pend = 1'b1;
        end else if (!wr_valid) begin
          wr_valid = ($urandom % 4) != 0;
        end
      end
      if (poke && loops == 20) begin
        busy_poke = busy;
        req_valid = 1'b1; req_read = !rd; req_addr = ~a;
      end else begin
        req_valid = 1'b0;
      end
      if (dcnt > 0) post++;
    end
    wr_valid = 1'b0;
    if (abort) return;
    h0 = {rd, 1'b1, 6'(len - 1)};
    chk(dcnt == 1, "R11 single done pulse", dcnt, 1);
    chk(errv == fail, "R7 error outcome", int'(errv), int'(fail));
    chk(csr == 1, "R4 one chip-select release", csr, 1);
    chk(bad_rises == b0, "R4 no clock outside frame", bad_rises - b0, 0);
    chk(cap[0] == h0, "R1 header byte 0", int'(cap[0]), int'(h0));
    chk({cap[1], cap[2], cap[3]} == a, "R2 address bytes", int'({cap[1], cap[2], cap[3]}), int'(a));
    if (poke) begin
      chk(busy_poke == 1'b1, "R10 poke landed while busy", int'(busy_poke), 1);
      chk(busy == 1'b0 && cs_n == 1'b1, "R10 no second access", int'({busy, cs_n}), 1);
    end
    if (!fail) begin
      chk(rises - r0 == 8 * (4 + n + len), n == 0 ? "R5 clock count no stall" : "R3 R6 clock count",
          rises - r0, 8 * (4 + n + len));
      chk(hi == (div + 1) * (rises - r0), "R9 high-phase length", hi, (div + 1) * (rises - r0));
    end
    if (rd) begin
      chk(rcnt == len, fail ? "R8 fill byte count" : "R3 read byte count", rcnt, len);
      bad = 0;
      for (int i = 0; i < len; i++)
        if (rbuf[i] !== (fail ? 8'h00 : rdat[i])) bad++;
      chk(bad == 0, fail ? "R8 zero fill data" : "R6 read data", bad, 0);
    end else begin
      chk(rcnt == 0, "R12 no read strobes on write", rcnt, 0);
      if (!fail) begin
        bad = 0;
        for (int i = 0; i < len; i++)
          if (cap[4 + n + i] !== wbuf[i]) bad++;
        chk(bad == 0, "R12 write data order", bad, 0);
        chk(widx == len, "R12 bytes taken", widx, len);
      end
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1, "R4 reset cs_n", int'(cs_n), 1);
    chk(sclk == 1'b0, "R9 reset sclk", int'(sclk), 0);
    chk(busy == 1'b0 && done == 1'b0 && rd_valid == 1'b0 && wr_ready == 1'b0,
        "R11 reset outputs", int'({busy, done, rd_valid, wr_ready}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_txn(1'b0, 1,  24'hD40018, 0, 0, 1'b0);  // R5 shortest write
    run_txn(1'b1, 64, 24'h123456, 0, 1, 1'b0);  // R3 longest read, R6 one poll
    run_txn(1'b1, 4,  24'hABCDEF, 1, 3, 1'b0);  // R7 tie: ready wins
    run_txn(1'b0, 7,  24'h00F000, 1, 3, 1'b0);  // R7 tie on write
    run_txn(1'b1, 5,  24'h0F0F0F, 1, 4, 1'b0);  // R7 R8 timeout read
    run_txn(1'b0, 9,  24'hFFFFFF, 1, 4, 1'b0);  // R7 timeout write
    run_txn(1'b1, 3,  24'h000024, 2, 0, 1'b1);  // R10 request while busy
    run_txn(1'b0, 12, 24'h5A5A5A, 3, 0, 1'b1);  // R10 R12

    for (int t = 0; t < 30; t++)
      run_txn(1'($urandom), int'($urandom % 64) + 1, 24'($urandom),
              int'($urandom % 4), int'($urandom % 3), 1'($urandom % 4 == 0));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule